// File: doc/BRIEF.md
# Synchronous Burst Read Latency Controller

This block sits in front of a burst-capable memory array and decides how each bus read is timed. A 16-bit configuration word, written through a simple strobe-and-data command port, chooses between asynchronous and synchronous reads, holds the initial latency code, records a power-down enable and chooses which clock edge is active for synchronous reads. The decoded fields are driven on output pins for the rest of the memory controller.

In synchronous mode, a read starts on an active clock edge where the address-latch strobe and the read enable are both high. The block then raises an in-latency flag and counts active edges. It drops the flag and gives a one-period first-data-valid pulse on the active edge that lies n+1 edges after the start, where n is the latency code. The active edge can be the rising or the falling edge of the clock. A configuration write never changes an access that is under way. The write waits and takes effect at the first rising edge where no access or pulse is in flight.

Top module: `burst_lat_ctrl`

## Requirements
- R1: After reset the outputs show async_mode=1, pwrdn_en=0, lat_code=7 and rise_edge=1. in_latency and first_valid are 0.
- R2: Configuration word fields are bit 15 for read mode (1 = asynchronous, 0 = synchronous), bits 13:11 for the latency code, bit 10 for power-down enable and bit 6 for the active edge (1 = rising, 0 = falling). The other bits are ignored. Suppose a write strobe is sampled on a rising edge while the block is idle. The new fields then appear on the outputs after the following rising edge.
- R3: A written latency code of 0 or 1 is rejected, and lat_code keeps its previous value. The other fields of the same write are still applied.
- R4: In asynchronous mode the address-latch strobe starts nothing, and in_latency and first_valid stay 0.
- R5: In synchronous mode, an access starts on an active edge that samples addr_latch=1 and rd_en=1. After that edge (edge 0), in_latency is 1 through edge n and drops at edge n+1.
- R6: first_valid is 1 for exactly one active-clock period, from edge n+1 to edge n+2.
- R7: With rise_edge=0, the start and every count happen on falling clock edges. With rise_edge=1 they happen on rising edges.
- R8: A write during an access leaves the outputs and the access timing unchanged until the access and its pulse are over. An address-latch strobe that arrives while a write is waiting is not accepted.
- R9: An address-latch strobe is ignored in two cases: while an access is already counting, and when rd_en=0.
- R10: first_valid and in_latency are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges used in synchronous mode |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe, sampled on rising edges |
| cfg_wdata | input | 16 | Configuration word |
| addr_latch | input | 1 | Address-latch strobe, sampled on the active edge |
| rd_en | input | 1 | Read enable qualifying addr_latch |
| async_mode | output | 1 | 1 = asynchronous reads selected |
| lat_code | output | 3 | Current latency code n |
| rise_edge | output | 1 | 1 = rising edge active, 0 = falling |
| pwrdn_en | output | 1 | Stored power-down enable |
| first_valid | output | 1 | One-period pulse when first data is valid |
| in_latency | output | 1 | High while the initial latency is counted |

## Verification
The assertions assume three things about the inputs. A strobe is held for a single active-clock period. A write never falls on the same edge as an address-latch strobe. Each input is stable around the edge that samples it. The bench drives writes just after rising edges, holds each for one period, and issues them only when the block is idle, except in the deliberate mid-access write. It lowers the strobe right after the start edge. The sweep covers every legal latency code with both active edges, and each expected cycle position is derived from the n+1 rule.

// File: rtl/blc_pkg.sv
package blc_pkg;
  localparam int CFG_W   = 16;
  localparam int LAT_W   = 3;
  localparam int LAT_MIN = 2;
  localparam int RSEL_BIT = 15;
  localparam int LAT_LSB  = 11;
  localparam int PDN_BIT  = 10;
  localparam int EDGE_BIT = 6;

  typedef struct packed {
    logic             async_rd;
    logic [LAT_W-1:0] lat;
    logic             pwrdn;
    logic             rise;
  } cfg_t;

  localparam cfg_t CFG_RST = '{async_rd: 1'b1, lat: {LAT_W{1'b1}}, pwrdn: 1'b0, rise: 1'b1};

  function automatic logic lat_ok(logic [LAT_W-1:0] code);
    return code >= LAT_W'(LAT_MIN);
  endfunction

  function automatic cfg_t merge_word(cfg_t old, logic [CFG_W-1:0] w);
    cfg_t n;
    n.async_rd = w[RSEL_BIT];
    n.lat      = lat_ok(w[LAT_LSB +: LAT_W]) ? w[LAT_LSB +: LAT_W] : old.lat;
    n.pwrdn    = w[PDN_BIT];
    n.rise     = w[EDGE_BIT];
    return n;
  endfunction
endpackage

// File: rtl/blc_cfg_reg.sv
module blc_cfg_reg
  import blc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             idle_i,
  output cfg_t             cfg_o,
  output logic             pend_o,
  output logic             commit_o
);
  logic [CFG_W-1:0] pend_w;

  assign commit_o = pend_o & idle_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_o  <= CFG_RST;
      pend_o <= 1'b0;
      pend_w <= '0;
    end else begin
      if (commit_o) cfg_o <= merge_word(cfg_o, pend_w);
      if (we_i) begin
        pend_o <= 1'b1;
        pend_w <= wdata_i;
      end else if (commit_o) begin
        pend_o <= 1'b0;
      end
    end
  end

  // R3
  lat_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> lat_ok(cfg_o.lat));
endmodule

// File: rtl/blc_lat_counter.sv
module blc_lat_counter
  import blc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic             busy_o,
  output logic             fv_o
);
  logic [LAT_W-1:0] cnt_q;
  logic [LAT_W-1:0] lat_q;
  logic             accept;
  logic             last_edge;

  assign accept    = start_i & ~busy_o;
  assign last_edge = busy_o & (cnt_q == lat_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      fv_o   <= 1'b0;
      cnt_q  <= '0;
      lat_q  <= '0;
    end else begin
      fv_o <= 1'b0;
      if (busy_o) begin
        if (last_edge) begin
          busy_o <= 1'b0;
          fv_o   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (accept) begin
        busy_o <= 1'b1;
        cnt_q  <= '0;
        lat_q  <= lat_i;
      end
    end
  end

  // R6
  fv_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fv_o |=> !fv_o);
  // R6
  fv_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fv_o) |-> $past(busy_o));
  // R5
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_o);
  // R10
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && fv_o));
endmodule

// File: rtl/burst_lat_ctrl.sv
module burst_lat_ctrl
  import blc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             addr_latch,
  input  logic             rd_en,
  output logic             async_mode,
  output logic [LAT_W-1:0] lat_code,
  output logic             rise_edge,
  output logic             pwrdn_en,
  output logic             first_valid,
  output logic             in_latency
);
  cfg_t       cfg;
  logic       pend;
  logic       commit;
  logic       idle;
  logic [1:0] busy_v;
  logic [1:0] fv_v;

  assign idle = ~(|busy_v) & ~(|fv_v);

  blc_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (cfg_we),
    .wdata_i  (cfg_wdata),
    .idle_i   (idle),
    .cfg_o    (cfg),
    .pend_o   (pend),
    .commit_o (commit)
  );

  // index 0 counts on rising edges, index 1 on falling edges
  for (genvar i = 0; i < 2; i++) begin : g_edge
    localparam bit RISE = (i == 0);
    logic ck;
    logic start;
    assign ck    = RISE ? clk : ~clk;
    assign start = addr_latch & rd_en & ~cfg.async_rd & ~pend & (cfg.rise == RISE);
    blc_lat_counter u_cnt (
      .clk_i   (ck),
      .rst_ni  (rst_n),
      .start_i (start),
      .lat_i   (cfg.lat),
      .busy_o  (busy_v[i]),
      .fv_o    (fv_v[i])
    );
  end

  assign async_mode  = cfg.async_rd;
  assign lat_code    = cfg.lat;
  assign rise_edge   = cfg.rise;
  assign pwrdn_en    = cfg.pwrdn;
  assign in_latency  = |busy_v;
  assign first_valid = |fv_v;

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_latency |=> $stable(cfg));
  // R4
  async_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    async_mode |-> (!in_latency && !first_valid));
  // R7
  one_domain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({busy_v, fv_v}) <= 1);
endmodule

// File: tb/tb_burst_lat_ctrl.sv
module tb_burst_lat_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        addr_latch = 1'b0;
  logic        rd_en = 1'b0;
  logic        async_mode, rise_edge, pwrdn_en, first_valid, in_latency;
  logic [2:0]  lat_code;
  int tests = 0;
  int fails = 0;

  always #(CLK_P/2) clk = ~clk;

  burst_lat_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .addr_latch(addr_latch), .rd_en(rd_en), .async_mode(async_mode),
    .lat_code(lat_code), .rise_edge(rise_edge), .pwrdn_en(pwrdn_en),
    .first_valid(first_valid), .in_latency(in_latency)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mkword(bit asy, int lat, bit pd, bit rise);
    logic [15:0] w = 16'h0000;
    w[15] = asy; w[13:11] = lat[2:0]; w[10] = pd; w[6] = rise;
    w[0] = 1'b1;
    return w;
  endfunction

  task automatic wr(logic [15:0] d);
    @(posedge clk); #2;
    cfg_we = 1'b1; cfg_wdata = d;
    @(posedge clk); #2;
    cfg_we = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic fields(string req, bit asy, int lat, bit pd, bit rise);
    chk(async_mode == asy, req, "async_mode", async_mode, asy);
    chk(lat_code == lat[2:0], req, "lat_code", lat_code, lat);
    chk(pwrdn_en == pd, req, "pwrdn_en", pwrdn_en, pd);
    chk(rise_edge == rise, req, "rise_edge", rise_edge, rise);
  endtask

  // go: access expected to start; lat: expected latency for this access
  task automatic access(string req, int lat, bit rise, bit go, bit rd,
                        bit rearm, bit midwr, logic [15:0] mw);
    @(posedge clk); #2;
    addr_latch = 1'b1; rd_en = rd;
    for (int k = 0; k <= lat + 3; k++) begin
      if (rise) @(posedge clk); else @(negedge clk);
      #1;
      chk(in_latency == (go && k <= lat), req, $sformatf("in_latency edge %0d", k),
          in_latency, go && k <= lat);
      chk(first_valid == (go && k == lat + 1), req, $sformatf("first_valid edge %0d", k),
          first_valid, go && k == lat + 1);
      chk(!(first_valid && in_latency), "R10", "both high", 1, 0);
      if (midwr && k >= 1 && k <= lat)
        chk(lat_code == lat[2:0], "R8", "lat_code mid-access", lat_code, lat);
      if (k == 0) begin addr_latch = 1'b0; rd_en = 1'b0; end
      if (rearm && k == 1) begin addr_latch = 1'b1; rd_en = 1'b1; end
      if (rearm && k == 2) begin addr_latch = 1'b0; rd_en = 1'b0; end
      if (midwr && k == 1) begin cfg_we = 1'b1; cfg_wdata = mw; end
      if (midwr && k == 2) cfg_we = 1'b0;
    end
    @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 2 + 3);
    // R1 reset state
    fields("R1", 1'b1, 7, 1'b0, 1'b1);
    chk(!in_latency && !first_valid, "R1", "idle flags", in_latency, 0);
    rst_n = 1'b1;
    // R4 async mode ignores strobe
    access("R4", 7, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
    // R2 R5 R6 R7 sweep of legal codes and both edges
    for (int e = 1; e >= 0; e--) begin
      for (int n = 2; n <= 7; n++) begin
        wr(mkword(1'b0, n, n[0], e[0]));
        fields("R2", 1'b0, n, n[0], e[0]);
        access(e ? "R5/R6" : "R7", n, e[0], 1'b1, 1'b1, 1'b0, 1'b0, 16'h0);
      end
    end
    // R3 rejected codes
    wr(mkword(1'b0, 5, 1'b0, 1'b1));
    wr(mkword(1'b0, 1, 1'b1, 1'b1));
    fields("R3", 1'b0, 5, 1'b1, 1'b1);
    wr(mkword(1'b0, 0, 1'b0, 1'b0));
    fields("R3", 1'b0, 5, 1'b0, 1'b0);
    // R9 strobe without read enable, then re-strobe while busy
    wr(mkword(1'b0, 4, 1'b0, 1'b1));
    access("R9", 4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
    access("R9", 4, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0);
    access("R9", 3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
    // R8 write during an access is deferred
    wr(mkword(1'b0, 7, 1'b0, 1'b1));
    access("R8", 7, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, mkword(1'b0, 2, 1'b1, 1'b1));
    fields("R8", 1'b0, 2, 1'b1, 1'b1);
    access("R8", 2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0);
    // R4 back to asynchronous
    wr(mkword(1'b1, 3, 1'b0, 1'b1));
    fields("R4", 1'b1, 3, 1'b0, 1'b1);
    access("R4", 3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule